// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block holds a small set of recent page-to-frame translations and answers lookups in the same cycle. Every stored translation carries the identifier of the address space it belongs to. Translations from several processes can therefore stay side by side, and a context switch does not force a flush. A requester presents a page number, the current address-space identifier and the page offset. Every entry is compared at once. The block answers with a hit, the frame number and the assembled physical address. Otherwise it raises a miss, and the requester must fetch the frame from the in-memory table.

Once the requester has resolved a translation, it installs it through the fill port. Installing never creates a second copy of a translation that is already held. A free slot is used first, and only when every slot is occupied does a rotating victim pointer choose the entry to replace. Two invalidation controls maintain the contents: one clears the whole buffer, and the other clears only the entries of a single address space.

Top module: `xlat_buffer`

## Requirements
- R1: A lookup with `lk_req` high hits when some valid entry holds both the presented page number and the presented identifier. `lk_pfn` then carries that entry's frame number; on a miss `lk_pfn` is zero.
- R2: `lk_paddr` is `{lk_pfn, lk_off}`: the frame number sits in the upper `PFN_W` bits and the offset passes through unchanged in the low `OFF_W` bits.
- R3: `lk_miss` is high exactly when `lk_req` is high and no entry matches. While `lk_req` is low, both `lk_hit` and `lk_miss` are low.
- R4: An entry whose page number matches but whose stored identifier differs from `lk_asid` does not hit.
- R5: After reset every entry is invalid, the victim pointer is at entry 0 and `dup_err` is low.
- R6: A fill whose page number and identifier match a valid entry rewrites that entry's frame number in place and occupies no other slot.
- R7: A fill of a new translation takes the lowest-numbered invalid entry when one exists.
- R8: When all entries are valid, a new translation replaces the entry at the victim pointer, and the pointer then advances by one, wrapping from the last entry to entry 0. Only such replacing fills move the pointer.
- R9: `inv_all` clears every entry's valid bit in a single cycle.
- R10: `inv_asid_en` clears only the entries whose identifier equals `inv_asid`; all other entries keep their translations.
- R11: When a fill and an invalidation share a cycle, the slot is chosen from the contents before the invalidation, the invalidation is applied, and the filled translation is then written as valid.
- R12: A lookup sees the contents present before any fill in the same cycle; the new translation becomes visible from the following cycle.
- R13: If two entries ever match one key, the lowest-numbered entry answers and the sticky `dup_err` rises until reset. Normal fills never create such a pair, so `dup_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W (20) | Page number to translate |
| lk_asid | input | ASID_W (8) | Current address-space identifier |
| lk_off | input | OFF_W (12) | Page offset |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup requested but not found |
| lk_pfn | output | PFN_W (20) | Frame number on a hit, zero otherwise |
| lk_paddr | output | PFN_W+OFF_W (32) | Frame number joined with the offset |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W (20) | Page number to install |
| fill_asid | input | ASID_W (8) | Identifier to install |
| fill_pfn | input | PFN_W (20) | Frame number to install |
| inv_all | input | 1 | Clear all entries |
| inv_asid_en | input | 1 | Clear entries of one identifier |
| inv_asid | input | ASID_W (8) | Identifier to clear |
| dup_err | output | 1 | Sticky flag: two entries matched one key |

## Verification
Two pairs of functions can fall in the same cycle. The first is a fill together with an invalidation, either a full flush or a flush of the very identifier being installed. The bench drives both on one clock edge, then looks up the new translation, which must hit, and the older ones, which must miss. The second pair is a lookup together with a fill of the same key. It is provoked by driving both between two edges: the lookup is judged as a miss in that cycle and as a hit in the next.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Where a fill lands
    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_MATCH  = 2'd1,
        SLOT_FREE   = 2'd2,
        SLOT_VICTIM = 2'd3
    } slot_src_e;

endpackage

// File: rtl/xlat_cam.sv
// Parallel key compare over all entries; lowest matching index wins.
module xlat_cam #(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][VPN_W-1:0]  tab_vpn,
    input  logic [N-1:0][ASID_W-1:0] tab_asid,
    input  logic [VPN_W-1:0]         key_vpn,
    input  logic [ASID_W-1:0]        key_asid,
    output logic                     hit,
    output logic [IDX_W-1:0]         idx,
    output logic                     multi
);
    logic [N-1:0] mvec;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign mvec[i] = valid[i] && (tab_vpn[i] == key_vpn) && (tab_asid[i] == key_asid);
    end

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mvec[i]) idx = IDX_W'(i);
        end
    end

    assign hit   = |mvec;
    assign multi = (mvec & (mvec - N'(1))) != '0;
endmodule

// File: rtl/xlat_alloc.sv
// Chooses the slot a fill writes: existing match, lowest free, or victim.
module xlat_alloc
    import xlat_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             fill_en,
    input  logic [N-1:0]     valid,
    input  logic             fill_hit,
    input  logic [IDX_W-1:0] fill_hit_idx,
    input  logic [IDX_W-1:0] rr_q,
    output logic [IDX_W-1:0] slot,
    output slot_src_e        src
);
    logic             any_free;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
        any_free = ~&valid;
    end

    always_comb begin
        slot = '0;
        src  = SLOT_NONE;
        if (fill_en) begin
            if (fill_hit) begin
                slot = fill_hit_idx;
                src  = SLOT_MATCH;
            end else if (any_free) begin
                slot = free_idx;
                src  = SLOT_FREE;
            end else begin
                slot = rr_q;
                src  = SLOT_VICTIM;
            end
        end
    end

    // R7: a free-slot fill never lands on an occupied entry
    always_comb begin
        if (src == SLOT_FREE) begin
            a_r7_free_is_empty: assert (!valid[slot]);
        end
    end
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int N      = 8,
    parameter int VPN_W  = 20,
    parameter int PFN_W  = 20,
    parameter int ASID_W = 8,
    parameter int OFF_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lk_req,
    input  logic [VPN_W-1:0]        lk_vpn,
    input  logic [ASID_W-1:0]       lk_asid,
    input  logic [OFF_W-1:0]        lk_off,
    output logic                    lk_hit,
    output logic                    lk_miss,
    output logic [PFN_W-1:0]        lk_pfn,
    output logic [PFN_W+OFF_W-1:0]  lk_paddr,
    input  logic                    fill_en,
    input  logic [VPN_W-1:0]        fill_vpn,
    input  logic [ASID_W-1:0]       fill_asid,
    input  logic [PFN_W-1:0]        fill_pfn,
    input  logic                    inv_all,
    input  logic                    inv_asid_en,
    input  logic [ASID_W-1:0]       inv_asid,
    output logic                    dup_err
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    typedef struct packed {
        logic [N-1:0]             valid;
        logic [N-1:0][VPN_W-1:0]  vpn;
        logic [N-1:0][ASID_W-1:0] asid;
        logic [N-1:0][PFN_W-1:0]  pfn;
        logic [IDX_W-1:0]         rr;
        logic                     dup;
    } state_t;

    state_t st_d, st_q;

    logic             lk_match, lk_multi;
    logic [IDX_W-1:0] lk_idx;
    logic             fl_match, fl_multi;
    logic [IDX_W-1:0] fl_idx;
    logic [IDX_W-1:0] slot;
    slot_src_e        src;
    logic [N-1:0]     clr;

    xlat_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_cam_lk (
        .valid    (st_q.valid),
        .tab_vpn  (st_q.vpn),
        .tab_asid (st_q.asid),
        .key_vpn  (lk_vpn),
        .key_asid (lk_asid),
        .hit      (lk_match),
        .idx      (lk_idx),
        .multi    (lk_multi)
    );

    xlat_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_cam_fill (
        .valid    (st_q.valid),
        .tab_vpn  (st_q.vpn),
        .tab_asid (st_q.asid),
        .key_vpn  (fill_vpn),
        .key_asid (fill_asid),
        .hit      (fl_match),
        .idx      (fl_idx),
        .multi    (fl_multi)
    );

    xlat_alloc #(.N(N), .IDX_W(IDX_W)) u_alloc (
        .fill_en      (fill_en),
        .valid        (st_q.valid),
        .fill_hit     (fl_match),
        .fill_hit_idx (fl_idx),
        .rr_q         (st_q.rr),
        .slot         (slot),
        .src          (src)
    );

    for (genvar i = 0; i < N; i++) begin : g_clr
        assign clr[i] = inv_all || (inv_asid_en && (st_q.asid[i] == inv_asid));
    end

    // Lookup outputs, combinational from the inputs and stored state
    always_comb begin
        lk_hit   = lk_req && lk_match;
        lk_miss  = lk_req && !lk_match;
        lk_pfn   = lk_hit ? st_q.pfn[lk_idx] : '0;
        lk_paddr = {lk_pfn, lk_off};
    end

    // Next state
    always_comb begin
        st_d       = st_q;
        st_d.valid = st_q.valid & ~clr;
        if (fill_en) begin
            st_d.valid[slot] = 1'b1;
            st_d.vpn[slot]   = fill_vpn;
            st_d.asid[slot]  = fill_asid;
            st_d.pfn[slot]   = fill_pfn;
            if (src == SLOT_VICTIM) begin
                st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + IDX_W'(1);
            end
        end
        st_d.dup = st_q.dup || (lk_req && lk_multi) || (fill_en && fl_multi);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
        end else begin
            st_q       <= st_d;
        end
    end

    assign dup_err = st_q.dup;

    // R3: a hit is only reported for a request
    always_comb begin
        if (lk_hit) begin
            a_r3_hit_needs_req: assert (lk_req);
        end
    end

    // R9: flush without fill leaves nothing valid
    a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !fill_en) |=> (st_q.valid == '0));

    // R10: an identifier flush never makes an entry valid
    a_r10_no_new_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_asid_en && !fill_en) |=> ((st_q.valid & ~$past(st_q.valid)) == '0));

    // R8: only replacing fills move the victim pointer
    a_r8_rr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_en && src == SLOT_VICTIM) |=> $stable(st_q.rr));

    // R11: a filled translation is always valid next cycle
    a_r11_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (st_q.valid != '0));

    // R13: deduplicating fills never produce a double match
    a_r13_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_err);
endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic [11:0] lk_off = '0;
    logic        lk_hit, lk_miss;
    logic [19:0] lk_pfn;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [7:0]  fill_asid = '0;
    logic [19:0] fill_pfn = '0;
    logic        inv_all = 1'b0;
    logic        inv_asid_en = 1'b0;
    logic [7:0]  inv_asid = '0;
    logic        dup_err;

    always #5 clk = ~clk;

    xlat_buffer u_xlat_buffer (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_off(lk_off),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
        .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid),
        .dup_err(dup_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference contents
    bit        m_v    [N];
    bit [19:0] m_vpn  [N];
    bit [7:0]  m_asid [N];
    bit [19:0] m_pfn  [N];
    int        m_rr = 0;

    typedef struct {
        bit        hit;
        bit [19:0] pfn;
        bit [31:0] pa;
        string     tag;
    } exp_t;

    exp_t scb[$];
    event ev_sample;

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t predict(bit [19:0] vpn, bit [7:0] asid, bit [11:0] off, string tag);
        exp_t e;
        e.hit = 0; e.pfn = '0; e.tag = tag;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) begin
                e.hit = 1; e.pfn = m_pfn[i];
            end
        end
        e.pa = {e.pfn, off};
        return e;
    endfunction

    // model update in requirement order: choose slot, invalidate, write
    task automatic model_step(bit f, bit [19:0] vpn, bit [7:0] asid, bit [19:0] pfn,
                              bit ia, bit ie, bit [7:0] iv);
        int slot = -1;
        if (f) begin
            for (int i = N - 1; i >= 0; i--)
                if (m_v[i] && m_vpn[i] == vpn && m_asid[i] == asid) slot = i;
            if (slot < 0)
                for (int i = N - 1; i >= 0; i--)
                    if (!m_v[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % N;
            end
        end
        for (int i = 0; i < N; i++)
            if (ia || (ie && m_asid[i] == iv)) m_v[i] = 0;
        if (f) begin
            m_v[slot] = 1; m_vpn[slot] = vpn; m_asid[slot] = asid; m_pfn[slot] = pfn;
        end
    endtask

    task automatic step(bit f, bit [19:0] vpn, bit [7:0] asid, bit [19:0] pfn,
                        bit ia, bit ie, bit [7:0] iv);
        @(negedge clk);
        fill_en = f; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        inv_all = ia; inv_asid_en = ie; inv_asid = iv;
        @(posedge clk);
        model_step(f, vpn, asid, pfn, ia, ie, iv);
        #1;
        fill_en = 0; inv_all = 0; inv_asid_en = 0;
    endtask

    task automatic fill(bit [19:0] vpn, bit [7:0] asid, bit [19:0] pfn);
        step(1, vpn, asid, pfn, 0, 0, 8'h0);
    endtask

    task automatic lookup(bit [19:0] vpn, bit [7:0] asid, bit [11:0] off, string tag);
        @(negedge clk);
        lk_req = 1; lk_vpn = vpn; lk_asid = asid; lk_off = off;
        scb.push_back(predict(vpn, asid, off, tag));
        #2;
        -> ev_sample;
        #1;
    endtask

    // monitor: compares design results against queued expectations
    initial begin
        forever begin
            exp_t e;
            @(ev_sample);
            e = scb.pop_front();
            check(lk_hit === e.hit, e.tag, "hit", 32'(lk_hit), 32'(e.hit));
            check(lk_miss === !e.hit, e.tag, "miss", 32'(lk_miss), 32'(!e.hit));
            check(lk_pfn === e.pfn, e.tag, "pfn", 32'(lk_pfn), 32'(e.pfn));
            check(lk_paddr === e.pa, e.tag, "paddr", lk_paddr, e.pa);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R5 and R3: quiet outputs after reset, no request
        @(negedge clk);
        check(lk_hit === 1'b0, "R5", "hit idle", 32'(lk_hit), 0);
        check(lk_miss === 1'b0, "R3", "miss idle", 32'(lk_miss), 0);
        check(dup_err === 1'b0, "R5", "dup_err", 32'(dup_err), 0);
        lookup(20'h00010, 8'd1, 12'h000, "R5 empty lookup");

        // R1 R2 R4
        fill(20'h00010, 8'd1, 20'hA0010);
        fill(20'h00011, 8'd1, 20'hA0011);
        fill(20'h00010, 8'd2, 20'hB0010);
        lookup(20'h00010, 8'd1, 12'hABC, "R1 R2 hit asid1");
        lookup(20'h00011, 8'd1, 12'hFFF, "R2 offset pass");
        lookup(20'h00010, 8'd2, 12'h123, "R4 same page other asid");
        lookup(20'h00010, 8'd3, 12'h123, "R4 unknown asid");
        lookup(20'h00012, 8'd1, 12'h001, "R3 miss");

        // R6 in-place update
        fill(20'h00010, 8'd1, 20'hC0010);
        lookup(20'h00010, 8'd1, 12'h004, "R6 updated frame");

        // fill the rest, then overflow: R8 victim order
        for (int i = 0; i < 5; i++) fill(20'h00100 + 20'(i), 8'd4, 20'hD0000 + 20'(i));
        lookup(20'h00104, 8'd4, 12'h010, "R7 last free slot");
        fill(20'h00200, 8'd5, 20'hE0200);
        lookup(20'h00010, 8'd1, 12'h000, "R8 victim0 evicted");
        lookup(20'h00200, 8'd5, 12'h000, "R8 new entry");
        fill(20'h00201, 8'd5, 20'hE0201);
        lookup(20'h00011, 8'd1, 12'h000, "R8 victim1 evicted");
        lookup(20'h00010, 8'd2, 12'h000, "R8 entry2 kept");

        // R10 clear one identifier
        step(0, '0, '0, '0, 0, 1, 8'd4);
        lookup(20'h00100, 8'd4, 12'h000, "R10 cleared");
        lookup(20'h00010, 8'd2, 12'h000, "R10 other kept");
        lookup(20'h00201, 8'd5, 12'h000, "R10 other kept 2");

        // R7 free slots reused before victim, then victim at pointer 2
        for (int i = 0; i < 5; i++) fill(20'h00300 + 20'(i), 8'd6, 20'hF0300 + 20'(i));
        lookup(20'h00010, 8'd2, 12'h000, "R7 entry2 survives free fills");
        fill(20'h00310, 8'd6, 20'hF0310);
        lookup(20'h00010, 8'd2, 12'h000, "R8 pointer reached entry2");
        lookup(20'h00300, 8'd6, 12'h000, "R7 entry kept");

        // R11 fill with full flush
        step(1, 20'h00400, 8'd7, 20'h11400, 1, 0, 8'h0);
        lookup(20'h00400, 8'd7, 12'h055, "R11 fill survives flush");
        lookup(20'h00300, 8'd6, 12'h000, "R9 R11 flushed");
        // R11 fill with flush of its own identifier
        step(1, 20'h00500, 8'd7, 20'h11500, 0, 1, 8'd7);
        lookup(20'h00400, 8'd7, 12'h000, "R11 old asid7 cleared");
        lookup(20'h00500, 8'd7, 12'h000, "R11 new asid7 valid");

        // R9 flush alone
        step(0, '0, '0, '0, 1, 0, 8'h0);
        lookup(20'h00500, 8'd7, 12'h000, "R9 empty after flush");

        // R12 lookup and fill of the same key in one cycle
        @(negedge clk);
        fill_en = 1; fill_vpn = 20'h00600; fill_asid = 8'd8; fill_pfn = 20'h22600;
        lk_req = 1; lk_vpn = 20'h00600; lk_asid = 8'd8; lk_off = 12'h0AA;
        scb.push_back(predict(20'h00600, 8'd8, 12'h0AA, "R12 same cycle miss"));
        #2 -> ev_sample;
        @(posedge clk);
        model_step(1, 20'h00600, 8'd8, 20'h22600, 0, 0, 8'h0);
        #1 fill_en = 0;
        lookup(20'h00600, 8'd8, 12'h0AA, "R12 next cycle hit");

        // R3 no request
        @(negedge clk);
        lk_req = 0;
        #1;
        check(lk_hit === 1'b0 && lk_miss === 1'b0, "R3", "idle flags",
              {30'd0, lk_hit, lk_miss}, 0);

        // R13 no duplicate ever formed
        check(dup_err === 1'b0, "R13", "dup_err", 32'(dup_err), 0);

        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule